// File: doc/BRIEF.md
# Half-Bridge Dead-Time and Blanking Sequencer

This block turns a one-bit switching command into the two gate signals of a half-bridge leg. A high command asks for the upper transistor to conduct and a low command asks for the lower one. When the command changes, the block first drops the gate that is on. It then waits a fixed dead time and raises the opposite gate. The two gates are never driven high together.

Each gate edge also starts a blanking window on two active-low outputs, one for each driver. Each of these outputs feeds the clock enable of the resynchronising flip-flop in its isolated driver. Both windows open a short, fixed delay after the gate edge, so that each flip-flop can capture the new gate level before it is frozen. Both windows then stay low for the blanking time, which covers the switch-node transition. Both drivers blank on every gate edge, because the direction of the load current decides which edge actually moves the switch node.

A command change that arrives while a sequence is running is not acted on at once. When the sequence finishes, the block samples the command level at that moment. All timings are parameters counted in clock cycles.

Top module: `hb_blank_seq`

## Requirements
- R1: `gate_hi` and `gate_lo` are never high in the same cycle. After a sequence completes, `gate_hi` is high when the latched command was 1, and `gate_lo` is high when it was 0.
- R2: A sequence starts when the block is idle (`busy` low) and `pwm_cmd` differs from the level currently applied. At the next clock edge, the conducting gate falls and `busy` rises, both on that same edge. Call this edge the start edge.
- R3: The opposite gate rises exactly DEAD_CYC clock edges after the start edge.
- R4: After each gate edge of a sequence (the start edge and the rising edge), both blanking outputs go low exactly BLANK_DLY_CYC edges later. They stay low for exactly BLANK_LEN_CYC cycles.
- R5: `blank_hi_n` and `blank_lo_n` are equal in every cycle.
- R6: Neither gate changes while the blanking outputs are low.
- R7: Changes of `pwm_cmd` while `busy` is high have no immediate effect. Once the block is idle again, the command level present then is compared against the applied level. A command that has returned to the applied level starts no sequence.
- R8: While `rst_n` is low, both gates and `busy` are low and both blanking outputs are high. The first command level seen after reset runs a full sequence: the start edge moves no gate, but it still opens a blanking window, and the gate for that level rises DEAD_CYC edges after the start edge.
- R9: `busy` falls on the same edge on which the second blanking window ends. That edge comes DEAD_CYC + BLANK_DLY_CYC + BLANK_LEN_CYC edges after the start edge. `busy` then stays low for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_cmd | input | 1 | Switching command: 1 for upper transistor on, 0 for lower |
| gate_hi | output | 1 | Gate command for the upper transistor |
| gate_lo | output | 1 | Gate command for the lower transistor |
| blank_hi_n | output | 1 | Active-low flip-flop enable for the upper driver |
| blank_lo_n | output | 1 | Active-low flip-flop enable for the lower driver |
| busy | output | 1 | High while a transition sequence runs |

## Verification
All results are counted from the start edge, which is the first clock edge after an idle cycle in which the command differs from the applied level. At that start edge the conducting gate falls and `busy` rises. The first blanking window opens BLANK_DLY_CYC edges after the start edge. The new gate rises DEAD_CYC edges after the start edge, and its blanking window opens BLANK_DLY_CYC edges after that. `busy` falls DEAD_CYC + BLANK_DLY_CYC + BLANK_LEN_CYC edges after the start edge. The bench drives `pwm_cmd` on falling edges and samples every output on the falling edge that follows the rising edge where it is due. It records the cycle of each start edge and each gate edge, and it measures the dead-time gap and the blanking delay as differences of those cycle numbers.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

  // True when k lies in the window [first, first+len).
  function automatic logic in_span(int unsigned k, int unsigned first, int unsigned len);
    return (k >= first) && (k < first + len);
  endfunction

endpackage

// File: rtl/hbs_seq_timer.sv
module hbs_seq_timer #(
  parameter int unsigned LAST = 12,
  localparam int unsigned CW = $clog2(LAST + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          run_q,
  output logic [CW-1:0] cnt_q,
  output logic          run_nx,
  output logic [CW-1:0] cnt_nx
);

  localparam logic [CW-1:0] END_M1 = CW'(LAST - 1);

  logic cnt_en;

  // Next-state logic
  always_comb begin
    run_nx = run_q;
    cnt_nx = cnt_q;
    if (start) begin
      run_nx = 1'b1;
      cnt_nx = '0;
    end else if (run_q) begin
      if (cnt_q == END_M1) begin
        run_nx = 1'b0;
        cnt_nx = '0;
      end else begin
        cnt_nx = cnt_q + 1'b1;
      end
    end
  end

  assign cnt_en = start | run_q;

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_nx;
      if (cnt_en) begin
        cnt_q <= cnt_nx;
      end
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (32'(cnt_q) < LAST)); // R9

endmodule

// File: rtl/hbs_gate_ctl.sv
module hbs_gate_ctl #(
  parameter int unsigned DEAD = 7,
  parameter int unsigned CW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd,
  input  logic          run_q,
  input  logic [CW-1:0] cnt_nx,
  output logic          start,
  output logic          gate_hi,
  output logic          gate_lo
);

  logic level_q, seen_q;
  logic level_nx, seen_nx, hi_nx, lo_nx;
  logic apply_on, gate_en;

  // A new sequence is launched only from idle.
  assign start    = !run_q && (!seen_q || (cmd != level_q));
  assign apply_on = run_q && (32'(cnt_nx) == DEAD);
  assign gate_en  = start | apply_on;

  // Next-state logic
  always_comb begin
    level_nx = level_q;
    seen_nx  = seen_q;
    hi_nx    = gate_hi;
    lo_nx    = gate_lo;
    if (start) begin
      level_nx = cmd;
      seen_nx  = 1'b1;
      hi_nx    = 1'b0;
      lo_nx    = 1'b0;
    end else if (apply_on) begin
      hi_nx    = level_q;
      lo_nx    = !level_q;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      seen_q  <= 1'b0;
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
    end else if (gate_en) begin
      level_q <= level_nx;
      seen_q  <= seen_nx;
      gate_hi <= hi_nx;
      gate_lo <= lo_nx;
    end
  end

  AST_GATE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo)); // R1

endmodule

// File: rtl/hbs_blank_gen.sv
module hbs_blank_gen
  import hbs_pkg::*;
#(
  parameter int unsigned DLY   = 2,
  parameter int unsigned LEN   = 3,
  parameter int unsigned DEAD  = 7,
  parameter int unsigned CW    = 4,
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_nx,
  input  logic [CW-1:0]    cnt_nx,
  output logic [LANES-1:0] blank_n
);

  logic win_nx;

  // One window after the turn-off edge, one after the turn-on edge.
  assign win_nx = run_nx &&
                  (in_span(32'(cnt_nx), DLY, LEN) ||
                   in_span(32'(cnt_nx), DEAD + DLY, LEN));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        blank_n[g] <= 1'b1;
      end else begin
        blank_n[g] <= !win_nx;
      end
    end
  end

endmodule

// File: rtl/hb_blank_seq.sv
module hb_blank_seq #(
  parameter int unsigned BLANK_DLY_CYC = 2,
  parameter int unsigned BLANK_LEN_CYC = 3,
  parameter int unsigned DEAD_CYC      = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_cmd,
  output logic gate_hi,
  output logic gate_lo,
  output logic blank_hi_n,
  output logic blank_lo_n,
  output logic busy
);

  localparam int unsigned LAST = DEAD_CYC + BLANK_DLY_CYC + BLANK_LEN_CYC;
  localparam int unsigned CW   = $clog2(LAST + 1);

  // Parameter legality: blanking must start after the edge and fit in the dead time.
  if (BLANK_DLY_CYC < 1 || BLANK_LEN_CYC < 1 ||
      DEAD_CYC < BLANK_DLY_CYC + BLANK_LEN_CYC) begin : g_bad_timing
    $error("hb_blank_seq: illegal timing parameters");
  end

  logic          start, run_q, run_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic [1:0]    blank_n;

  hbs_seq_timer #(.LAST(LAST)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .run_q  (run_q),
    .cnt_q  (cnt_q),
    .run_nx (run_nx),
    .cnt_nx (cnt_nx)
  );

  hbs_gate_ctl #(.DEAD(DEAD_CYC), .CW(CW)) u_gates (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (pwm_cmd),
    .run_q   (run_q),
    .cnt_nx  (cnt_nx),
    .start   (start),
    .gate_hi (gate_hi),
    .gate_lo (gate_lo)
  );

  hbs_blank_gen #(
    .DLY   (BLANK_DLY_CYC),
    .LEN   (BLANK_LEN_CYC),
    .DEAD  (DEAD_CYC),
    .CW    (CW),
    .LANES (2)
  ) u_blank (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_nx  (run_nx),
    .cnt_nx  (cnt_nx),
    .blank_n (blank_n)
  );

  assign blank_hi_n = blank_n[1];
  assign blank_lo_n = blank_n[0];
  assign busy       = run_q;

  AST_FALL_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate_hi) || $fell(gate_lo)) |-> (run_q && cnt_q == '0)); // R2

  AST_RISE_AT_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_hi) || $rose(gate_lo)) |-> (run_q && 32'(cnt_q) == DEAD_CYC)); // R3

  AST_BLANK_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blank_hi_n) |-> (32'(cnt_q) == BLANK_DLY_CYC ||
                           32'(cnt_q) == DEAD_CYC + BLANK_DLY_CYC)); // R4

  AST_BLANK_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    blank_hi_n == blank_lo_n); // R5

  AST_GATE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_hi_n |-> $stable({gate_hi, gate_lo})); // R6

  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $rose(blank_lo_n)); // R9

endmodule

// File: tb/test_hb_blank_seq.sv
module test_hb_blank_seq;

  localparam int D = 2;
  localparam int B = 3;
  localparam int T = 7;
  localparam int LAST = T + D + B;

  logic clk, rst_n, pwm_cmd;
  logic gate_hi, gate_lo, blank_hi_n, blank_lo_n, busy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  hb_blank_seq #(.BLANK_DLY_CYC(D), .BLANK_LEN_CYC(B), .DEAD_CYC(T)) i_hb_blank_seq (
    .clk(clk), .rst_n(rst_n), .pwm_cmd(pwm_cmd),
    .gate_hi(gate_hi), .gate_lo(gate_lo),
    .blank_hi_n(blank_hi_n), .blank_lo_n(blank_lo_n), .busy(busy)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  function automatic bit in_win(int k);
    return (k >= D && k < D + B) || (k >= T + D && k < T + D + B);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // Reference model of the requirements, advanced on each rising edge.
  bit m_run, m_lvl, m_seen, m_hi, m_lo;
  int m_k;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run <= 0; m_k <= 0; m_lvl <= 0; m_seen <= 0; m_hi <= 0; m_lo <= 0;
    end else if (!m_run) begin
      if (!m_seen || pwm_cmd != m_lvl) begin
        m_run <= 1; m_k <= 0; m_lvl <= pwm_cmd; m_seen <= 1; m_hi <= 0; m_lo <= 0;
      end
    end else begin
      if (m_k + 1 == LAST) begin m_run <= 0; m_k <= 0; end
      else m_k <= m_k + 1;
      if (m_k + 1 == T) begin m_hi <= m_lvl; m_lo <= !m_lvl; end
    end
  end

  // Output and event checks on the falling edge.
  bit p_hi, p_lo, p_bn, p_busy;
  int start_cyc = -100;
  int edge_cyc = -100;
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      chk("R8 gate_hi in reset", gate_hi, 0);
      chk("R8 gate_lo in reset", gate_lo, 0);
      chk("R8 blank_hi_n in reset", blank_hi_n, 1);
      chk("R8 blank_lo_n in reset", blank_lo_n, 1);
      chk("R8 busy in reset", busy, 0);
    end else begin
      chk("R1 gate exclusion", gate_hi & gate_lo, 0);
      chk("R1 gate_hi", gate_hi, m_hi);
      chk("R1 gate_lo", gate_lo, m_lo);
      chk("R4 blank_hi_n", blank_hi_n, !(m_run && in_win(m_k)));
      chk("R5 blank pair", blank_hi_n, blank_lo_n);
      chk("R9 busy", busy, m_run);
      if (busy && !p_busy) begin
        chk("R9 idle gap before start", cyc - start_cyc > LAST, 1);
        start_cyc = cyc;
        edge_cyc = cyc;
      end
      if ((p_hi && !gate_hi) || (p_lo && !gate_lo))
        chk("R2 fall on start edge", cyc - start_cyc, 0);
      if ((!p_hi && gate_hi) || (!p_lo && gate_lo)) begin
        chk("R3 dead gap", cyc - start_cyc, T);
        edge_cyc = cyc;
      end
      if (p_bn && !blank_hi_n)
        chk("R4 blank delay", cyc - edge_cyc, D);
      if (!blank_hi_n)
        chk("R6 gates frozen", {gate_hi, gate_lo}, {p_hi, p_lo});
    end
    p_hi = gate_hi; p_lo = gate_lo; p_bn = blank_hi_n; p_busy = busy;
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  initial begin
    void'($urandom(32'd7301));
    rst_n = 0;
    pwm_cmd = 1;
    wait_cyc(4);
    rst_n = 1;
    // R8: first level after reset runs a full sequence
    wait_cyc(1);
    chk("R8 busy after first edge", busy, 1);
    wait_cyc(LAST + 4);
    chk("R8 gate_hi after first sequence", gate_hi, 1);
    // Plain toggles
    pwm_cmd = 0;
    wait_cyc(LAST + 5);
    chk("R1 lo side on", gate_lo, 1);
    // R7: glitch during busy that returns to the applied level
    pwm_cmd = 1;
    wait_cyc(3);
    pwm_cmd = 0;
    wait_cyc(2);
    pwm_cmd = 1;
    wait_idle();
    wait_cyc(5);
    chk("R7 no second sequence", busy, 0);
    chk("R7 hi side kept", gate_hi, 1);
    // R7: change during busy is taken after idle
    pwm_cmd = 0;
    wait_cyc(4);
    pwm_cmd = 1;
    wait_cyc(2);
    pwm_cmd = 0;
    wait_idle();
    wait_cyc(LAST + 4);
    chk("R7 latest level applied", gate_lo, 1);
    // Random stretch
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 6 == 0) pwm_cmd = ~pwm_cmd;
      @(negedge clk);
    end
    wait_cyc(2 * LAST);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule